// File: doc/BRIEF.md
# Serial-Steered Tree Cell Selector

This block picks one cell out of a small array by steering through a binary tree of three-state routing nodes. No full address decoder is used. The address arrives one bit per transfer at the root. Each bit travels down the tree, one level per clock, until it meets the first undecided node. That node keeps the bit as a direction (left for 0, right for 1), and the bit goes no further. After all address bits have settled, exactly one root-to-leaf path is decided, and every other node remains idle.

A start strobe then launches a bus token. The token follows the decided path to the leaf, picks up that cell's content, and climbs back to the root. On the way up it returns every node it passes to the idle state. When the token reaches the root, the read data is presented with a one-cycle done pulse, and the tree is ready for the next access.

A plain write port preloads the cell array. A count of non-idle nodes is brought out, so that the path can be watched from outside.

Top module: `bb_tree_router`

## Requirements
- R1: After reset, every node is idle, `live_nodes` is 0, `addr_ready` is 1, `rd_done` is 0.
- R2: An idle node that an address bit reaches keeps it: 0 makes the node steer left and 1 makes it steer right. The bit travels no further, so exactly one more node leaves idle.
- R3: A node that is already steering passes any arriving address bit or bus token to its left or right child, according to its direction, and its own direction stays unchanged.
- R4: Bits are taken first bit first. The first bit sets the root, and the selected cell index is the bits read as a binary number with the first bit as the most significant bit. For example, bits 0,1,0 select cell 2.
- R5: Each signal moves one tree level per clock. Bit number k (counting from 0) is accepted on one clock edge and settles k+1 edges later. `addr_ready` stays low while a bit is in flight.
- R6: `live_nodes` equals the number of settled bits during the address phase, and it never exceeds ADDR_BITS.
- R7: `bus_start` is ignored unless exactly ADDR_BITS bits have settled and none is in flight. During the bus phase, and once ADDR_BITS bits are held, `addr_ready` is 0 and offered bits are refused.
- R8: `rd_done` pulses for one cycle, 2*ADDR_BITS+1 clock edges after the edge that accepts `bus_start`. In that same cycle `rd_data` holds the content of the addressed cell.
- R9: When `rd_done` is high, every node is idle (`live_nodes` is 0), and a new address may begin on the next cycle.
- R10: When `wr_en` is high at a clock edge, `wr_data` is stored into cell `wr_idx`, and a later read of that cell returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | An address bit is offered |
| addr_bit | input | 1 | Address bit value: 0 steers left, 1 steers right |
| addr_ready | output | 1 | The root can take a bit this cycle |
| bus_start | input | 1 | Strobe that launches the bus token |
| rd_data | output | DATA_W | Content of the addressed cell |
| rd_done | output | 1 | One-cycle pulse when the read completes |
| wr_en | input | 1 | Preload write enable |
| wr_idx | input | ADDR_BITS | Preload cell index |
| wr_data | input | DATA_W | Preload data |
| live_nodes | output | ADDR_BITS | Number of nodes that are not idle |

## Verification
An accepted bit number k raises `live_nodes` exactly k+1 edges after its accept edge. The bench counts falling edges from that accept edge until the count moves and compares the total with k+1. The read is due 2*ADDR_BITS+1 edges after the start edge. The bench counts edges from the falling edge that follows the strobe up to the first sample where `rd_done` is high, then compares the data and the idle tree in that same sample. All inputs change on falling edges and all outputs are sampled there, so every check sits half a period away from the register updates it observes.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  typedef enum logic [1:0] {
    ND_WAIT  = 2'd0,
    ND_LEFT  = 2'd1,
    ND_RIGHT = 2'd2
  } node_st_t;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DOWN = 2'd1,
    PH_UP   = 2'd2
  } phase_t;
endpackage

// File: rtl/bbr_node.sv
module bbr_node
  import bbr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_en,
  input  logic     go_right,
  input  logic     clr_en,
  output node_st_t state
);
  always_ff @(posedge clk) begin
    if (!rst_n)      state <= ND_WAIT;
    else if (set_en) state <= go_right ? ND_RIGHT : ND_LEFT;
    else if (clr_en) state <= ND_WAIT;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ND_WAIT && !set_en) |=> state == ND_WAIT); // R2
  AST_TAKES_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> state == ($past(go_right) ? ND_RIGHT : ND_LEFT)); // R2
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ND_WAIT && !clr_en) |=> $stable(state)); // R3
endmodule

// File: rtl/bbr_cells.sv
module bbr_cells #(
  parameter int ADDR_BITS = 3,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_BITS-1:0] rd_idx,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int NCELLS = 1 << ADDR_BITS;

  logic [DATA_W-1:0] mem [NCELLS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data; // R10
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/bb_tree_router.sv
module bb_tree_router
  import bbr_pkg::*;
#(
  parameter int ADDR_BITS = 3,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_valid,
  input  logic                 addr_bit,
  output logic                 addr_ready,
  input  logic                 bus_start,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_done,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [ADDR_BITS-1:0] live_nodes
);
  localparam int NCELLS = 1 << ADDR_BITS;
  localparam int NNODES = NCELLS - 1;
  localparam int IDX_W  = ADDR_BITS + 1;
  localparam logic [ADDR_BITS-1:0] FULL = ADDR_BITS'(ADDR_BITS);
  localparam logic [IDX_W-1:0] FIRST_LEAF = IDX_W'(NNODES);

  // heap numbering: root 0, children 2i+1 and 2i+2, leaves from NNODES
  function automatic logic [IDX_W-1:0] child_of(input logic [IDX_W-1:0] i,
                                                input logic go_right);
    return (i << 1) + IDX_W'(1) + IDX_W'(go_right);
  endfunction

  function automatic logic [IDX_W-1:0] parent_of(input logic [IDX_W-1:0] i);
    return (i - IDX_W'(1)) >> 1;
  endfunction

  function automatic logic [ADDR_BITS-1:0] cell_of(input logic [IDX_W-1:0] i);
    return ADDR_BITS'(i - FIRST_LEAF);
  endfunction

  node_st_t          st [NNODES];
  logic [NNODES-1:0] set_en, clr_en, busy_vec;

  logic                 flit_v, flit_bit;
  logic [IDX_W-1:0]     flit_idx;
  node_st_t             flit_st, bus_st;
  phase_t               phase;
  logic [IDX_W-1:0]     bus_ptr, up_parent;
  logic [ADDR_BITS-1:0] bits_in;
  logic [DATA_W-1:0]    cell_rd, rd_q;
  logic                 done_q;

  // named internal events
  logic accept, flit_settle, start_ok, bus_at_leaf, tree_done;

  always_comb begin
    flit_st = ND_WAIT;
    bus_st  = ND_WAIT;
    for (int i = 0; i < NNODES; i++) begin
      if (flit_idx == IDX_W'(i)) flit_st = st[i];
      if (bus_ptr == IDX_W'(i))  bus_st  = st[i];
    end
  end

  assign addr_ready  = (phase == PH_ADDR) && !flit_v && (bits_in != FULL);
  assign accept      = addr_valid && addr_ready;
  assign flit_settle = flit_v && (flit_st == ND_WAIT);
  assign start_ok    = bus_start && (phase == PH_ADDR) && !flit_v && (bits_in == FULL);
  assign bus_at_leaf = bus_ptr >= FIRST_LEAF;
  assign up_parent   = parent_of(bus_ptr);
  assign tree_done   = (phase == PH_UP) && (up_parent == '0);

  for (genvar g = 0; g < NNODES; g++) begin : g_node
    assign set_en[g]   = flit_settle && (flit_idx == IDX_W'(g));
    assign clr_en[g]   = (phase == PH_UP) && (up_parent == IDX_W'(g));
    assign busy_vec[g] = (st[g] != ND_WAIT);
    bbr_node u_node (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_en[g]),
      .go_right (flit_bit),
      .clr_en   (clr_en[g]),
      .state    (st[g])
    );
  end

  always_comb begin
    live_nodes = '0;
    for (int i = 0; i < NNODES; i++) live_nodes = live_nodes + ADDR_BITS'(busy_vec[i]);
  end

  bbr_cells #(.ADDR_BITS(ADDR_BITS), .DATA_W(DATA_W)) u_cells (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (cell_of(bus_ptr)),
    .rd_data (cell_rd)
  );

  // address bit in flight: one level per clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flit_v   <= 1'b0;
      flit_bit <= 1'b0;
      flit_idx <= '0;
      bits_in  <= '0;
    end else begin
      if (accept) begin
        flit_v   <= 1'b1;
        flit_bit <= addr_bit;
        flit_idx <= '0;
      end else if (flit_settle) begin
        flit_v <= 1'b0;
      end else if (flit_v) begin
        flit_idx <= child_of(flit_idx, flit_st == ND_RIGHT);
      end
      if (flit_settle)    bits_in <= bits_in + ADDR_BITS'(1);
      else if (tree_done) bits_in <= '0;
    end
  end

  // bus token: down the carved path, read the leaf, climb back clearing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_ADDR;
      bus_ptr <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_ADDR: if (start_ok) begin
          phase   <= PH_DOWN;
          bus_ptr <= '0;
        end
        PH_DOWN: if (bus_at_leaf) begin
          rd_q  <= cell_rd;
          phase <= PH_UP;
        end else begin
          bus_ptr <= child_of(bus_ptr, bus_st == ND_RIGHT);
        end
        PH_UP: begin
          bus_ptr <= up_parent;
          if (tree_done) begin
            done_q <= 1'b1;
            phase  <= PH_ADDR;
          end
        end
        default: phase <= PH_ADDR;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign rd_done = done_q;

  AST_LIVE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    live_nodes <= FULL); // R6
  AST_LIVE_TRACKS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && !flit_v) |-> live_nodes == bits_in); // R6
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> live_nodes == '0); // R9
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && bits_in != FULL) |=> phase == PH_ADDR); // R7
  AST_BUS_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_ADDR) |-> !addr_ready); // R7
  AST_INFLIGHT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flit_v |-> !addr_ready); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done); // R8
endmodule

// File: tb/bb_tree_router_tb.sv
`timescale 1ns/1ps
module bb_tree_router_tb;
  localparam int N  = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_valid = 1'b0, addr_bit = 1'b0, bus_start = 1'b0, wr_en = 1'b0;
  logic [N-1:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic addr_ready, rd_done;
  logic [DW-1:0] rd_data;
  logic [N-1:0] live_nodes;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  bb_tree_router #(.ADDR_BITS(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_bit(addr_bit),
    .addr_ready(addr_ready), .bus_start(bus_start), .rd_data(rd_data),
    .rd_done(rd_done), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .live_nodes(live_nodes)
  );

  // {cell index, content}
  localparam logic [N+DW-1:0] VEC [8] = '{
    {3'd5, 8'hA5}, {3'd0, 8'h3C}, {3'd7, 8'hFF}, {3'd2, 8'h00},
    {3'd3, 8'h81}, {3'd6, 8'h7E}, {3'd1, 8'h12}, {3'd4, 8'hC9}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cell(input logic [N-1:0] idx, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // bit number k: settle due k+1 edges after the accept edge
  task automatic send_bit(input logic b, input int k);
    int g = 0;
    int cnt = 0;
    while (!addr_ready && g < 50) begin @(negedge clk); g++; end
    addr_valid = 1'b1; addr_bit = b;
    @(negedge clk);
    addr_valid = 1'b0;
    while (live_nodes != N'(k + 1) && cnt < 50) begin @(negedge clk); cnt++; end
    chk(cnt == k + 1, "R5 settle edges", cnt, k + 1);
    chk(live_nodes == N'(k + 1), "R2/R6 live after bit", live_nodes, k + 1);
  endtask

  task automatic send_addr(input logic [N-1:0] a);
    for (int k = 0; k < N; k++) send_bit(a[N-1-k], k);
  endtask

  task automatic run_bus(input logic [DW-1:0] exp, input string tag);
    int cnt = 0;
    @(negedge clk);
    bus_start = 1'b1;
    @(negedge clk);
    bus_start = 1'b0;
    while (!rd_done && cnt < 50) begin @(negedge clk); cnt++; end
    chk(cnt == 2 * N + 1, "R8 done latency", cnt, 2 * N + 1);
    chk(rd_data == exp, tag, rd_data, exp);
    chk(live_nodes == 0, "R9 tree idle at done", live_nodes, 0);
    @(negedge clk);
    chk(!rd_done, "R8 done one cycle", rd_done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(live_nodes == 0, "R1 live", live_nodes, 0);
    chk(addr_ready == 1'b1, "R1 ready", addr_ready, 1);
    chk(rd_done == 1'b0, "R1 done", rd_done, 0);

    for (int i = 0; i < 8; i++) write_cell(VEC[i][N+DW-1:DW], VEC[i][DW-1:0]);

    // table walk: every path, R3 forwarding and R4 bit order
    for (int i = 0; i < 8; i++) begin
      send_addr(VEC[i][N+DW-1:DW]);
      chk(addr_ready == 1'b0, "R7 full refuses", addr_ready, 0);
      run_bus(VEC[i][DW-1:0], "R3/R4 read data");
    end

    // R4: bits 0,1,0 select cell 2
    write_cell(3'd2, 8'h6B);
    send_bit(1'b0, 0); send_bit(1'b1, 1); send_bit(1'b0, 2);
    run_bus(8'h6B, "R4 bits 0,1,0 -> cell 2");

    // R10: overwrite then read back
    write_cell(3'd5, 8'h5A);
    send_addr(3'd5);
    run_bus(8'h5A, "R10 rewrite");

    // R7: strobe with too few bits is ignored
    send_bit(1'b1, 0); send_bit(1'b1, 1);
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
    cnt = 0;
    repeat (12) begin @(negedge clk); if (rd_done) cnt++; end
    chk(cnt == 0, "R7 early strobe no done", cnt, 0);
    chk(live_nodes == 2, "R7 early strobe tree kept", live_nodes, 2);
    chk(addr_ready == 1'b1, "R7 still takes bits", addr_ready, 1);
    send_bit(1'b1, 2);
    run_bus(8'hFF, "R7 read after early strobe");

    // R7: bits offered during the bus phase are refused
    send_addr(3'd0);
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0; addr_valid = 1'b1; addr_bit = 1'b1;
    chk(addr_ready == 1'b0, "R7 ready low in bus phase", addr_ready, 0);
    cnt = 0;
    while (!rd_done && cnt < 50) begin @(negedge clk); cnt++; end
    addr_valid = 1'b0;
    chk(rd_data == 8'h3C, "R7 read with bits offered", rd_data, 8'h3C);
    chk(live_nodes == 0, "R7/R9 refused bits left no node", live_nodes, 0);
    @(negedge clk);
    chk(live_nodes == 0, "R7 no late bit", live_nodes, 0);

    // R9: next access right after done
    send_addr(3'd6);
    run_bus(8'h7E, "R9 back-to-back");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule